// File: doc/BRIEF.md
# System Control Interrupt Aggregator and Address Decoder

This block is the byte-addressed control front end of a multi-function I/O companion device. Up to eight level-sensitive interrupt lines from the device's peripherals feed a status register. The status is ANDed with a mask register and the result drives one combined interrupt to the host processor. Line 0 belongs to the NAND controller, line 1 to the MMC controller, line 2 to the USB host, line 3 to the serial port and line 4 to the framebuffer. Lines 5 to 7 are spare.

The host reaches the block through a 64 KiB window. The upper address byte picks a region: page 0 holds the system control registers and page 1 holds a small configuration space. Any other page belongs to a relocatable peripheral data window. That window is hit only when its programmed page matches and its enable bit is set. On a hit the byte lanes are passed out to the peripheral, and read data is taken back from it.

The host may issue 8-, 16- or 32-bit accesses. The block splits each one into little-endian byte accesses, one per lane, all handled in the same cycle. Clock, PLL and mode registers are plain byte storage, and each byte lane of them is written on its own.

Top module: `ioc_sysctl`

## Requirements
- R1: After reset the interrupt status, the mask, the window enable and page, and all storage registers are zero, and `host_irq` is low.
- R2: When `irq_lines[n]` differs from its value in the previous cycle, status bit n takes the new level at the next clock edge. Status bit n is read at system-control offset 0x50.
- R3: `host_irq` is high exactly while (status AND mask) is nonzero, with the mask at offset 0x52. It reflects any status or mask update in the cycle after the edge that stores it.
- R4: Software may write the status byte at 0x50. In a cycle where a line also changes, that line's bit takes the line level and the software value is discarded for that bit.
- R5: Offset 0x08 reads 0x03 and offset 0x09 reads 0x00. Writes to either offset have no effect.
- R6: `bus_addr[15:8]` = 0x00 selects the system control page and 0x01 selects the configuration page. Any other page hits the data window only when it equals the programmed window page and the window is enabled. A lane that hits nothing reads 0x00, and writes to it are dropped.
- R7: In the configuration page, offset 0x04 bit 1 is the window enable, which reads back as 0x02 or 0x00. Offset 0x10 holds the 8-bit window page.
- R8: `bus_size` 0 is a byte access, 1 is a 16-bit access (addr, addr+1) and 2 or 3 is a 32-bit access (addr to addr+3). Data bits [8k+7:8k] belong to addr+k. Read lanes beyond the access size return zero.
- R9: These storage bytes are read/write: 0x54 (routing), 0x60-0x61, 0x98-0x99, 0x9A-0x9B, 0x9C-0x9F, 0xE0, 0xE4-0xE5, 0xFC and 0xFF. A write changes only the lanes it addresses.
- R10: Unmapped offsets in the system control and configuration pages read 0x00, and writes to them change nothing.
- R11: A window hit raises `win_wr` or `win_rd`. `win_lanes` marks the hit lanes, and `win_addr`/`win_wdata` carry the host address and data. Read lanes that hit the window return the same lane of `win_rdata`.
- R12: `bus_rdata` is loaded at the clock edge where `bus_rd` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 8 | Peripheral interrupt levels |
| host_irq | output | 1 | Combined masked interrupt |
| bus_addr | input | 16 | Host byte address |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2/3 word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data, lane k for addr+k |
| bus_rdata | output | 32 | Registered read data |
| win_wr | output | 1 | Data window write |
| win_rd | output | 1 | Data window read |
| win_lanes | output | 4 | Lanes hitting the data window |
| win_addr | output | 16 | Address forwarded to the window |
| win_wdata | output | 32 | Data forwarded to the window |
| win_rdata | input | 32 | Read data from the window |

## Verification
The embedded assertions check several rules on every cycle:
- a changed line lands in its status bit one edge later;
- a zero mask keeps `host_irq` low;
- no lane in pages 0 or 1 is routed to the data window;
- storage bytes never move without a host write;
- a byte read of offset 0x08 returns the revision code;
- read data holds between reads.

Some behaviour only the bench scenarios can show. These are lane preservation in the multi-byte registers, zero fill of unused read lanes, and accesses that straddle a page boundary. They also include the enable and page gating of the window and the precedence of a line change over a same-cycle software write to the status byte.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_SCR  = 2'd1,
    RG_CFG  = 2'd2,
    RG_WIN  = 2'd3
  } region_e;

  localparam int NSLOT   = 16;
  localparam int SLOT_IW = $clog2(NSLOT);

  typedef struct packed {
    logic               hit;
    logic [SLOT_IW-1:0] idx;
  } slot_t;

  localparam logic [7:0] OFF_REV_LO   = 8'h08;
  localparam logic [7:0] OFF_REV_HI   = 8'h09;
  localparam logic [7:0] OFF_STAT     = 8'h50;
  localparam logic [7:0] OFF_MASK     = 8'h52;
  localparam logic [7:0] CFG_OFF_EN   = 8'h04;
  localparam logic [7:0] CFG_OFF_BASE = 8'h10;
  localparam logic [7:0] REV_CODE     = 8'h03;

  // Map a system-control offset onto a plain storage byte slot.
  function automatic slot_t slot_of(input logic [7:0] off);
    slot_t s;
    s.hit = 1'b1;
    s.idx = '0;
    case (off)
      8'h54:   s.idx = SLOT_IW'(0);
      8'h60:   s.idx = SLOT_IW'(1);
      8'h61:   s.idx = SLOT_IW'(2);
      8'h98:   s.idx = SLOT_IW'(3);
      8'h99:   s.idx = SLOT_IW'(4);
      8'h9a:   s.idx = SLOT_IW'(5);
      8'h9b:   s.idx = SLOT_IW'(6);
      8'h9c:   s.idx = SLOT_IW'(7);
      8'h9d:   s.idx = SLOT_IW'(8);
      8'h9e:   s.idx = SLOT_IW'(9);
      8'h9f:   s.idx = SLOT_IW'(10);
      8'he0:   s.idx = SLOT_IW'(11);
      8'he4:   s.idx = SLOT_IW'(12);
      8'he5:   s.idx = SLOT_IW'(13);
      8'hfc:   s.idx = SLOT_IW'(14);
      8'hff:   s.idx = SLOT_IW'(15);
      default: s.hit = 1'b0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ioc_lane_split.sv
module ioc_lane_split #(
  parameter int ADDR_W = 16,
  parameter int LANES  = 4
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic [1:0]                    size,
  output logic [LANES-1:0][ADDR_W-1:0]  lane_addr,
  output logic [LANES-1:0]              lane_act
);

  int nbytes;

  always_comb begin
    case (size)
      2'd0:    nbytes = 1;
      2'd1:    nbytes = 2;
      default: nbytes = 4;
    endcase
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_addr[k] = addr + ADDR_W'(k);
    assign lane_act[k]  = (k < nbytes);
  end

endmodule

// File: rtl/ioc_region_dec.sv
module ioc_region_dec
  import ioc_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int PAGE_W = ADDR_W - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lane_addr,
  input  logic              lane_act,
  input  logic [PAGE_W-1:0] win_page,
  input  logic              win_en,
  output region_e           region
);

  logic [PAGE_W-1:0] page;
  assign page = lane_addr[ADDR_W-1:8];

  always_comb begin
    if (!lane_act)                          region = RG_NONE;
    else if (page == PAGE_W'(0))            region = RG_SCR;
    else if (page == PAGE_W'(1))            region = RG_CFG;
    else if (win_en && (page == win_page))  region = RG_WIN;
    else                                    region = RG_NONE;
  end

  AST_WIN_NOT_LOW_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RG_WIN) |-> (page > PAGE_W'(1)) && win_en); // R6

endmodule

// File: rtl/ioc_irq_agg.sv
module ioc_irq_agg #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_lines,
  input  logic             stat_we,
  input  logic [N_IRQ-1:0] stat_d,
  input  logic             mask_we,
  input  logic [N_IRQ-1:0] mask_d,
  output logic [N_IRQ-1:0] stat_q,
  output logic [N_IRQ-1:0] mask_q,
  output logic             irq_out
);

  logic [N_IRQ-1:0] seen_q;
  logic [N_IRQ-1:0] stat_n;
  logic [N_IRQ-1:0] mask_n;

  always_comb begin
    for (int i = 0; i < N_IRQ; i++) begin
      if (irq_lines[i] != seen_q[i]) stat_n[i] = irq_lines[i];
      else if (stat_we)              stat_n[i] = stat_d[i];
      else                           stat_n[i] = stat_q[i];
    end
    mask_n = mask_we ? mask_d : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      seen_q <= irq_lines;
      stat_q <= stat_n;
      mask_q <= mask_n;
    end
  end

  assign irq_out = |(stat_q & mask_q);

  for (genvar i = 0; i < N_IRQ; i++) begin : g_chk
    AST_LINE_TO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_lines[i] != seen_q[i]) |=> (stat_q[i] == $past(irq_lines[i]))); // R2
  end

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_out); // R3

endmodule

// File: rtl/ioc_scr_store.sv
module ioc_scr_store #(
  parameter int NSLOT = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSLOT-1:0]      slot_we,
  input  logic [NSLOT-1:0][7:0] slot_wd,
  output logic [NSLOT-1:0][7:0] slot_q
);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic [7:0] nxt;
    assign nxt = slot_we[i] ? slot_wd[i] : slot_q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[i] <= '0;
      else        slot_q[i] <= nxt;
    end
  end

endmodule

// File: rtl/ioc_sysctl.sv
module ioc_sysctl
  import ioc_pkg::*;
#(
  parameter int N_IRQ      = 8,
  parameter int ADDR_W     = 16,
  parameter int DATA_BYTES = 4,
  localparam int LANES  = DATA_BYTES,
  localparam int DW     = 8 * DATA_BYTES,
  localparam int PAGE_W = ADDR_W - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  irq_lines,
  output logic              host_irq,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              win_wr,
  output logic              win_rd,
  output logic [LANES-1:0]  win_lanes,
  output logic [ADDR_W-1:0] win_addr,
  output logic [DW-1:0]     win_wdata,
  input  logic [DW-1:0]     win_rdata
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // Lane split and per-lane region decode
  logic [LANES-1:0][ADDR_W-1:0] lane_addr;
  logic [LANES-1:0]             lane_act;
  region_e                      lane_rg [LANES];
  logic                         win_en_q;
  logic [PAGE_W-1:0]            win_page_q;

  ioc_lane_split #(.ADDR_W(ADDR_W), .LANES(LANES)) u_split (
    .addr      (bus_addr),
    .size      (bus_size),
    .lane_addr (lane_addr),
    .lane_act  (lane_act)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_dec
    ioc_region_dec #(.ADDR_W(ADDR_W)) u_dec (
      .clk       (clk),
      .rst_n     (rst_i_n),
      .lane_addr (lane_addr[k]),
      .lane_act  (lane_act[k]),
      .win_page  (win_page_q),
      .win_en    (win_en_q),
      .region    (lane_rg[k])
    );
    assign win_lanes[k] = (lane_rg[k] == RG_WIN);
  end

  assign win_wr    = bus_wr & (|win_lanes);
  assign win_rd    = bus_rd & (|win_lanes);
  assign win_addr  = bus_addr;
  assign win_wdata = bus_wdata;

  // Write decode
  logic                  stat_we, mask_we, en_we, page_we;
  logic [N_IRQ-1:0]      stat_d, mask_d;
  logic                  en_d;
  logic [PAGE_W-1:0]     page_d;
  logic [NSLOT-1:0]      slot_we;
  logic [NSLOT-1:0][7:0] slot_wd;

  always_comb begin
    slot_t      ws;
    logic [7:0] wb;
    stat_we = 1'b0;  stat_d  = '0;
    mask_we = 1'b0;  mask_d  = '0;
    en_we   = 1'b0;  en_d    = 1'b0;
    page_we = 1'b0;  page_d  = '0;
    slot_we = '0;    slot_wd = '0;
    for (int k = 0; k < LANES; k++) begin
      wb = bus_wdata[8*k +: 8];
      ws = slot_of(lane_addr[k][7:0]);
      if (bus_wr) begin
        case (lane_rg[k])
          RG_SCR: begin
            if (lane_addr[k][7:0] == OFF_STAT) begin
              stat_we = 1'b1;
              stat_d  = wb[N_IRQ-1:0];
            end else if (lane_addr[k][7:0] == OFF_MASK) begin
              mask_we = 1'b1;
              mask_d  = wb[N_IRQ-1:0];
            end else if (ws.hit) begin
              slot_we[ws.idx] = 1'b1;
              slot_wd[ws.idx] = wb;
            end
          end
          RG_CFG: begin
            if (lane_addr[k][7:0] == CFG_OFF_EN) begin
              en_we = 1'b1;
              en_d  = wb[1];
            end else if (lane_addr[k][7:0] == CFG_OFF_BASE) begin
              page_we = 1'b1;
              page_d  = wb[PAGE_W-1:0];
            end
          end
          default: ;
        endcase
      end
    end
  end

  // Interrupt aggregation and storage
  logic [N_IRQ-1:0]      stat_q, mask_q;
  logic [NSLOT-1:0][7:0] slot_q;

  ioc_irq_agg #(.N_IRQ(N_IRQ)) u_irq (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .irq_lines (irq_lines),
    .stat_we   (stat_we),
    .stat_d    (stat_d),
    .mask_we   (mask_we),
    .mask_d    (mask_d),
    .stat_q    (stat_q),
    .mask_q    (mask_q),
    .irq_out   (host_irq)
  );

  ioc_scr_store #(.NSLOT(NSLOT)) u_store (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .slot_we (slot_we),
    .slot_wd (slot_wd),
    .slot_q  (slot_q)
  );

  // Window configuration registers
  logic              win_en_n;
  logic [PAGE_W-1:0] win_page_n;

  always_comb begin
    win_en_n   = en_we   ? en_d   : win_en_q;
    win_page_n = page_we ? page_d : win_page_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      win_en_q   <= 1'b0;
      win_page_q <= '0;
    end else begin
      win_en_q   <= win_en_n;
      win_page_q <= win_page_n;
    end
  end

  // Read mux and registered read data
  logic [7:0]    stat_b, mask_b, page_b;
  logic [DW-1:0] rd_n;
  logic [DW-1:0] rdata_q;

  always_comb begin
    stat_b = '0;  stat_b[N_IRQ-1:0]  = stat_q;
    mask_b = '0;  mask_b[N_IRQ-1:0]  = mask_q;
    page_b = '0;  page_b[PAGE_W-1:0] = win_page_q;
  end

  always_comb begin
    slot_t      rs;
    logic [7:0] off;
    rd_n = '0;
    for (int k = 0; k < LANES; k++) begin
      off = lane_addr[k][7:0];
      rs  = slot_of(off);
      case (lane_rg[k])
        RG_SCR: begin
          if (off == OFF_REV_LO)     rd_n[8*k +: 8] = REV_CODE;
          else if (off == OFF_STAT)  rd_n[8*k +: 8] = stat_b;
          else if (off == OFF_MASK)  rd_n[8*k +: 8] = mask_b;
          else if (rs.hit)           rd_n[8*k +: 8] = slot_q[rs.idx];
        end
        RG_CFG: begin
          if (off == CFG_OFF_EN)        rd_n[8*k +: 8] = {6'b0, win_en_q, 1'b0};
          else if (off == CFG_OFF_BASE) rd_n[8*k +: 8] = page_b;
        end
        RG_WIN:  rd_n[8*k +: 8] = win_rdata[8*k +: 8];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_n;
  end

  assign bus_rdata = rdata_q;

  AST_REV_READ: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_rd && bus_size == 2'd0 && bus_addr == ADDR_W'(OFF_REV_LO))
      |=> (bus_rdata[7:0] == REV_CODE)); // R5

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_i_n)
    !bus_rd |=> $stable(bus_rdata)); // R12

  AST_STORE_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_i_n)
    !bus_wr |=> $stable(slot_q)); // R9

  AST_WIN_STROBE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_i_n)
    (win_wr || win_rd) |-> win_en_q && (bus_wr || bus_rd)); // R11

endmodule

// File: tb/test_ioc_sysctl.sv
`timescale 1ns/1ps
module test_ioc_sysctl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  irq_lines;
  logic        host_irq;
  logic [15:0] bus_addr;
  logic [1:0]  bus_size;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic        win_wr, win_rd;
  logic [3:0]  win_lanes;
  logic [15:0] win_addr;
  logic [31:0] win_wdata;
  logic [31:0] win_rdata;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  ioc_sysctl i_ioc_sysctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .host_irq  (host_irq),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .win_wr    (win_wr),
    .win_rd    (win_rd),
    .win_lanes (win_lanes),
    .win_addr  (win_addr),
    .win_wdata (win_wdata),
    .win_rdata (win_rdata)
  );

  // Scoreboard: expected read data queued by the driver
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_pipe = 1'b0;

  always @(posedge clk) rd_pipe <= bus_rd;

  always @(negedge clk) begin
    if (rd_pipe && exp_q.size() > 0) begin
      logic [31:0] e;
      string       t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        failures++;
        $display("FAIL %s actual=%08h expected=%08h", t, bus_rdata, e);
      end
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
    checks++;
    if (act !== e) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", t, act, e);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [1:0] sz,
                    input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_wr = 1'b0; bus_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
    end
  endtask

  task automatic set_lines(input logic [7:0] v);
    @(negedge clk);
    irq_lines = v; bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_lines = '0; bus_addr = '0; bus_size = '0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0; win_rdata = 32'hA5B6C7D8;
    idle(3);
    chk("R1 host_irq in reset", {31'b0, host_irq}, 32'h0);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 host_irq after reset", {31'b0, host_irq}, 32'h0);
    rd(16'h0050, 2'd2, 32'h0, "R1 status/mask zero");
    rd(16'h0098, 2'd2, 32'h0, "R1 clock storage zero");
    rd(16'h0104, 2'd0, 32'h0, "R1 window disabled");

    // R5 revision
    rd(16'h0008, 2'd2, 32'h00000003, "R5 revision word");
    wr(16'h0008, 2'd0, 32'hFF);
    rd(16'h0008, 2'd0, 32'h03, "R5 revision after write");

    // R9 / R8 storage byte lanes
    wr(16'h009C, 2'd2, 32'h11223344);
    rd(16'h009C, 2'd2, 32'h11223344, "R9 PLL1 word");
    wr(16'h009E, 2'd0, 32'h000000AA);
    rd(16'h009C, 2'd2, 32'h11AA3344, "R9 lane preserved");
    rd(16'h009C, 2'd0, 32'h00000044, "R8 byte read upper lanes zero");
    wr(16'h0098, 2'd1, 32'h0000BEEF);
    rd(16'h0098, 2'd1, 32'h0000BEEF, "R9 clock half");
    rd(16'h009A, 2'd1, 32'h00000000, "R9 neighbour untouched");
    wr(16'h0061, 2'd0, 32'h5A);
    rd(16'h0060, 2'd1, 32'h00005A00, "R9 high lane only");
    wr(16'h0054, 2'd0, 32'h07);
    rd(16'h0054, 2'd0, 32'h07, "R9 routing byte");
    wr(16'h00FF, 2'd0, 32'h77);
    rd(16'h00FF, 2'd1, 32'h00000077, "R8 page-crossing half");

    // R10 unmapped
    wr(16'h0030, 2'd0, 32'hFF);
    rd(16'h0030, 2'd0, 32'h0, "R10 unmapped scr");

    // R2 / R3 / R4 interrupts
    set_lines(8'h05);
    idle(1);
    chk("R3 mask zero keeps irq low", {31'b0, host_irq}, 32'h0);
    rd(16'h0050, 2'd0, 32'h05, "R2 status follows lines");
    wr(16'h0052, 2'd0, 32'h04);
    idle(1);
    chk("R3 irq after mask write", {31'b0, host_irq}, 32'h1);
    set_lines(8'h01);
    idle(1);
    chk("R2 line fall clears irq", {31'b0, host_irq}, 32'h0);
    rd(16'h0050, 2'd0, 32'h01, "R2 status after fall");
    set_lines(8'h81);
    wr(16'h0052, 2'd0, 32'h80);
    idle(1);
    chk("R3 bit7 irq", {31'b0, host_irq}, 32'h1);
    wr(16'h0050, 2'd0, 32'h0C);
    idle(1);
    chk("R4 software clear drops irq", {31'b0, host_irq}, 32'h0);
    rd(16'h0050, 2'd0, 32'h0C, "R4 software status write");
    @(negedge clk);
    irq_lines = 8'h89;
    bus_addr = 16'h0050; bus_size = 2'd0; bus_wdata = 32'h0; bus_wr = 1'b1; bus_rd = 1'b0;
    rd(16'h0050, 2'd0, 32'h08, "R4 line change wins");
    rd(16'h0050, 2'd2, 32'h00800008, "R8 word over status/mask");

    // R6 / R7 / R11 window
    rd(16'h4004, 2'd2, 32'h0, "R6 window disabled reads zero");
    #1 chk("R6 no window strobe", {31'b0, win_rd}, 32'h0);
    wr(16'h0110, 2'd0, 32'h40);
    wr(16'h0104, 2'd0, 32'hFF);
    rd(16'h0104, 2'd0, 32'h02, "R7 enable readback");
    rd(16'h0110, 2'd0, 32'h40, "R7 page readback");
    wr(16'h0112, 2'd0, 32'hFF);
    rd(16'h0110, 2'd2, 32'h00000040, "R10 unmapped cfg");
    rd(16'h4004, 2'd2, 32'hA5B6C7D8, "R11 window read data");
    #1 chk("R11 win_rd", {31'b0, win_rd}, 32'h1);
    chk("R11 win_lanes word", {28'b0, win_lanes}, 32'hF);
    wr(16'h4006, 2'd1, 32'h00001234);
    #1 chk("R11 win_wr", {31'b0, win_wr}, 32'h1);
    chk("R11 win_lanes half", {28'b0, win_lanes}, 32'h3);
    chk("R11 win_addr", {16'b0, win_addr}, 32'h4006);
    chk("R11 win_wdata", win_wdata, 32'h00001234);
    rd(16'h40FF, 2'd1, 32'h000000D8, "R6 lane past page misses");
    rd(16'h4104, 2'd0, 32'h0, "R6 wrong page");
    #1 chk("R6 wrong page no strobe", {31'b0, win_rd}, 32'h0);
    wr(16'h0104, 2'd0, 32'h00);
    rd(16'h4004, 2'd2, 32'h0, "R6 disabled again");

    // R12 hold
    rd(16'h009C, 2'd2, 32'h11AA3344, "R12 last read");
    idle(3);
    chk("R12 rdata holds", bus_rdata, 32'h11AA3344);

    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule